// File: doc/BRIEF.md
# Programmable Raster Sync Generator

This block produces the horizontal sync, vertical sync, blanking and data-enable strobes that drive a raster display panel from a pixel clock. Every timing edge is held as an absolute position, counted from the first pixel or first line of the sync pulse. The block does not store porch lengths. A horizontal counter walks each line. A vertical counter advances once per line. Compare logic on each axis decides whether the raster position lies inside sync and inside the visible window.

Software sets the timing through a narrow write port of nine position registers. Every write lands in a shadow copy. The live timing takes the shadow values only at a frame boundary, or continuously while the generator is stopped. A frame that has started therefore always finishes on the timing it began with. A further register names a line whose first pixel raises a single-cycle event pulse. It is typically the line where the vertical front porch begins.

The controller has two states. `ST_OFF` holds both counters at zero and parks every strobe at its inactive level. `ST_RUN` scans the raster. The transition `ST_OFF -> ST_RUN` is taken on a clock edge that sees `enable` high. The transition `ST_RUN -> ST_OFF` is taken on an edge that sees `enable` low. Otherwise each state holds.

Top module: `raster_timing_gen`

## Requirements
- R1: While running, the horizontal position counts 0 to H_TOTAL-1 and then wraps to 0. The line number advances only at that wrap and returns to 0 after line V_TOTAL-1, so one frame lasts H_TOTAL*V_TOTAL clocks.
- R2: Sync is active on `hsync` while the horizontal position is below H_SYNC_END. Sync is active on `vsync` while the line number is below V_SYNC_END.
- R3: `de` is high only when H_ACT_START <= position < H_ACT_END and V_ACT_START <= line < V_ACT_END. `blank` is at its active level whenever the generator runs and `de` is low, and at its inactive level whenever `de` is high.
- R4: While `de` is high, `pix_x` equals position minus H_ACT_START and `pix_y` equals line minus V_ACT_START. While `de` is low, both are zero.
- R5: `vevent_irq` pulses high for exactly one clock, at position 0 of line V_EVENT.
- R6: Each of `hs_pol`, `vs_pol` and `blank_pol` sets the active level of its own output: 1 makes it active-high, 0 makes it active-low.
- R7: One clock after an edge that samples `enable` low, `hsync`, `vsync` and `blank` sit at their inactive levels, and `de`, `pix_x`, `pix_y` and `vevent_irq` are all 0. After an edge that samples `enable` high from the stopped state, the raster starts at position 0 of line 0.
- R8: Write addresses select the registers as follows: 0 H_TOTAL, 1 H_SYNC_END, 2 H_ACT_START, 3 H_ACT_END, 4 V_TOTAL, 5 V_SYNC_END, 6 V_ACT_START, 7 V_ACT_END, 8 V_EVENT. A write to any address of 9 or above changes nothing.
- R9: While running, a written value reaches the live timing only at the wrap from the last position of the last line to the frame origin. While stopped, it reaches the live timing before the next start.
- R10: After reset the generator is stopped. Every register holds its parameter default, which is H 28/4/7/23 and V 13/2/4/10, with V_EVENT 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run (1) or stop (0) the sync generator |
| hs_pol | input | 1 | Horizontal sync active level |
| vs_pol | input | 1 | Vertical sync active level |
| blank_pol | input | 1 | Blank active level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index |
| wr_data | input | CW (12) | Register write value |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| blank | output | 1 | Blanking strobe |
| de | output | 1 | Data enable |
| pix_x | output | CW (12) | Column within the visible window |
| pix_y | output | CW (12) | Row within the visible window |
| vevent_irq | output | 1 | Single-cycle vertical event pulse |

## Verification
The strobes, coordinates and event pulse are decoded without registers from the two counter registers. Each result therefore belongs to the raster position that the counters hold in that cycle. After the edge that starts the generator, position t of the scan appears t clocks later. A stop shows at the outputs one clock after the edge that samples `enable` low. A write made mid-frame first shows in the frame that follows the next origin. The bench drives inputs and samples outputs on falling edges. It keeps its own scan index, which is reset at each start. It compares every output only after the exact number of rising edges that index implies.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
    localparam int NREG = 9;
    localparam int AW   = $clog2(NREG);

    localparam int RI_H_TOTAL     = 0;
    localparam int RI_H_SYNC_END  = 1;
    localparam int RI_H_ACT_START = 2;
    localparam int RI_H_ACT_END   = 3;
    localparam int RI_V_TOTAL     = 4;
    localparam int RI_V_SYNC_END  = 5;
    localparam int RI_V_ACT_START = 6;
    localparam int RI_V_ACT_END   = 7;
    localparam int RI_V_EVENT     = 8;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } rtg_state_e;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
    import rtg_pkg::*;
#(
    parameter int                   CW       = 12,
    parameter logic [NREG*CW-1:0]   DEFAULTS = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [CW-1:0]        wr_data,
    input  logic                 load,
    output logic [NREG*CW-1:0]   live
);
    logic [NREG*CW-1:0] shadow_q;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        // Shadow copy: written by software at any time.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow_q[i*CW +: CW] <= DEFAULTS[i*CW +: CW];
            end else if (wr_en && (wr_addr == AW'(i))) begin
                shadow_q[i*CW +: CW] <= wr_data;
            end
        end

        // Live copy: follows the shadow only when the controller allows it.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                live[i*CW +: CW] <= DEFAULTS[i*CW +: CW];
            end else if (load) begin
                live[i*CW +: CW] <= shadow_q[i*CW +: CW];
            end
        end
    end
endmodule

// File: rtl/rtg_axis_counter.sv
module rtg_axis_counter #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic [CW-1:0] total,
    output logic [CW-1:0] cnt,
    output logic          wrap
);
    logic [CW-1:0] last;

    assign last = total - CW'(1);
    assign wrap = step && (cnt == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= wrap ? '0 : cnt + CW'(1);
        end
    end
endmodule

// File: rtl/rtg_axis_decode.sv
module rtg_axis_decode #(
    parameter int CW = 12
) (
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] sync_end,
    input  logic [CW-1:0] act_start,
    input  logic [CW-1:0] act_end,
    output logic          in_sync,
    output logic          in_act,
    output logic [CW-1:0] offs
);
    assign in_sync = (cnt < sync_end);
    assign in_act  = (cnt >= act_start) && (cnt < act_end);
    assign offs    = cnt - act_start;
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int CW          = 12,
    parameter int H_TOTAL     = 28,
    parameter int H_SYNC_END  = 4,
    parameter int H_ACT_START = 7,
    parameter int H_ACT_END   = 23,
    parameter int V_TOTAL     = 13,
    parameter int V_SYNC_END  = 2,
    parameter int V_ACT_START = 4,
    parameter int V_ACT_END   = 10,
    parameter int V_EVENT     = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          hs_pol,
    input  logic          vs_pol,
    input  logic          blank_pol,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    output logic          hsync,
    output logic          vsync,
    output logic          blank,
    output logic          de,
    output logic [CW-1:0] pix_x,
    output logic [CW-1:0] pix_y,
    output logic          vevent_irq
);
    // Register defaults packed with index 0 at the least significant slot.
    localparam logic [NREG*CW-1:0] DEFAULTS = {
        CW'(V_EVENT), CW'(V_ACT_END), CW'(V_ACT_START), CW'(V_SYNC_END),
        CW'(V_TOTAL), CW'(H_ACT_END), CW'(H_ACT_START), CW'(H_SYNC_END),
        CW'(H_TOTAL)
    };

    rtg_state_e         state_q, state_d;
    logic               run;
    logic               load;
    logic [NREG*CW-1:0] cfg;

    logic [CW-1:0] cfg_htotal, cfg_hsync, cfg_hstart, cfg_hend;
    logic [CW-1:0] cfg_vtotal, cfg_vsync, cfg_vstart, cfg_vend, cfg_vevent;

    logic [CW-1:0] hcnt, vcnt;
    logic          h_wrap, v_wrap;
    logic          h_sync, h_act, v_sync, v_act;
    logic [CW-1:0] h_offs, v_offs;

    assign cfg_htotal = cfg[RI_H_TOTAL*CW     +: CW];
    assign cfg_hsync  = cfg[RI_H_SYNC_END*CW  +: CW];
    assign cfg_hstart = cfg[RI_H_ACT_START*CW +: CW];
    assign cfg_hend   = cfg[RI_H_ACT_END*CW   +: CW];
    assign cfg_vtotal = cfg[RI_V_TOTAL*CW     +: CW];
    assign cfg_vsync  = cfg[RI_V_SYNC_END*CW  +: CW];
    assign cfg_vstart = cfg[RI_V_ACT_START*CW +: CW];
    assign cfg_vend   = cfg[RI_V_ACT_END*CW   +: CW];
    assign cfg_vevent = cfg[RI_V_EVENT*CW     +: CW];

    // ---------------- controller: state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- controller: next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  state_d = enable ? ST_RUN : ST_OFF;
            ST_RUN:  state_d = enable ? ST_RUN : ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    assign run  = (state_q == ST_RUN);
    // Live timing follows the shadow while stopped, and at the frame origin while running.
    assign load = !run || (h_wrap && v_wrap);

    rtg_regs #(
        .CW       (CW),
        .DEFAULTS (DEFAULTS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load    (load),
        .live    (cfg)
    );

    rtg_axis_counter #(.CW(CW)) u_hcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!run),
        .step  (run),
        .total (cfg_htotal),
        .cnt   (hcnt),
        .wrap  (h_wrap)
    );

    rtg_axis_counter #(.CW(CW)) u_vcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!run),
        .step  (h_wrap),
        .total (cfg_vtotal),
        .cnt   (vcnt),
        .wrap  (v_wrap)
    );

    rtg_axis_decode #(.CW(CW)) u_hdec (
        .cnt       (hcnt),
        .sync_end  (cfg_hsync),
        .act_start (cfg_hstart),
        .act_end   (cfg_hend),
        .in_sync   (h_sync),
        .in_act    (h_act),
        .offs      (h_offs)
    );

    rtg_axis_decode #(.CW(CW)) u_vdec (
        .cnt       (vcnt),
        .sync_end  (cfg_vsync),
        .act_start (cfg_vstart),
        .act_end   (cfg_vend),
        .in_sync   (v_sync),
        .in_act    (v_act),
        .offs      (v_offs)
    );

    // ---------------- controller: outputs ----------------
    always_comb begin
        hsync      = ~hs_pol;
        vsync      = ~vs_pol;
        blank      = ~blank_pol;
        de         = 1'b0;
        pix_x      = '0;
        pix_y      = '0;
        vevent_irq = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                // all strobes parked at their inactive levels
            end
            ST_RUN: begin
                de         = h_act && v_act;
                hsync      = h_sync ? hs_pol : ~hs_pol;
                vsync      = v_sync ? vs_pol : ~vs_pol;
                blank      = (h_act && v_act) ? ~blank_pol : blank_pol;
                pix_x      = (h_act && v_act) ? h_offs : '0;
                pix_y      = (h_act && v_act) ? v_offs : '0;
                vevent_irq = (hcnt == '0) && (vcnt == cfg_vevent);
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker #(
    parameter int CW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic          hs_pol,
    input logic          blank_pol,
    input logic          hsync,
    input logic          blank,
    input logic          de,
    input logic          vevent_irq,
    input logic [CW-1:0] pix_x,
    input logic [CW-1:0] pix_y,
    input logic          run,
    input logic [CW-1:0] hcnt,
    input logic [CW-1:0] vcnt,
    input logic [CW-1:0] act_hstart
);
    assert_hstep_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && hcnt != '0) |-> (hcnt == CW'($past(hcnt) + CW'(1))));

    assert_vhold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && hcnt != '0) |-> $stable(vcnt));

    assert_de_unblanked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (blank == ~blank_pol));

    assert_xy_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !de |-> (pix_x == '0 && pix_y == '0));

    assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vevent_irq |=> !vevent_irq);

    assert_off_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!de && !vevent_irq && hsync == ~hs_pol));

    assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && (hcnt != '0 || vcnt != '0)) |-> $stable(act_hstart));
endmodule

bind raster_timing_gen rtg_checker #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .hs_pol     (hs_pol),
    .blank_pol  (blank_pol),
    .hsync      (hsync),
    .blank      (blank),
    .de         (de),
    .vevent_irq (vevent_irq),
    .pix_x      (pix_x),
    .pix_y      (pix_y),
    .run        (run),
    .hcnt       (hcnt),
    .vcnt       (vcnt),
    .act_hstart (cfg_hstart)
);

// File: tb/raster_timing_gen_tb.sv
`timescale 1ns/1ps
module raster_timing_gen_tb;
    localparam int CW = 12;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          hs_pol = 1'b1, vs_pol = 1'b1, blank_pol = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic          hsync, vsync, blank, de, vevent_irq;
    logic [CW-1:0] pix_x, pix_y;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  t       = 0;
    bit  done    = 1'b0;

    always #2 clk = ~clk;

    raster_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .hs_pol(hs_pol), .vs_pol(vs_pol), .blank_pol(blank_pol),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hsync(hsync), .vsync(vsync), .blank(blank), .de(de),
        .pix_x(pix_x), .pix_y(pix_y), .vevent_irq(vevent_irq)
    );

    // Default timing: line 28 clocks, frame 13 lines.
    // Entry: {scan index, hs, vs, blank, de, irq, x, y}
    localparam int NV = 13;
    localparam logic [36:0] VEC [NV] = '{
        {16'd0,   5'b11100, 8'd0,  8'd0},
        {16'd3,   5'b11100, 8'd0,  8'd0},
        {16'd4,   5'b01100, 8'd0,  8'd0},
        {16'd7,   5'b01100, 8'd0,  8'd0},
        {16'd56,  5'b10100, 8'd0,  8'd0},
        {16'd119, 5'b00010, 8'd0,  8'd0},
        {16'd134, 5'b00010, 8'd15, 8'd0},
        {16'd135, 5'b00100, 8'd0,  8'd0},
        {16'd262, 5'b00010, 8'd3,  8'd5},
        {16'd280, 5'b10101, 8'd0,  8'd0},
        {16'd281, 5'b10100, 8'd0,  8'd0},
        {16'd363, 5'b00100, 8'd0,  8'd0},
        {16'd364, 5'b11100, 8'd0,  8'd0}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (scan %0d)", req, what, act, exp, t);
        end
    endtask

    task automatic step1();
        @(posedge clk);
        @(negedge clk);
        t++;
    endtask

    task automatic adv_to(input int target);
        while (t < target) step1();
    endtask

    task automatic wr(input int a, input int d);
        wr_en   = 1'b1;
        wr_addr = AW'(a);
        wr_data = CW'(d);
        step1();
        wr_en   = 1'b0;
    endtask

    // Stop, wait, start: leaves the bench at scan index 0 of a fresh frame.
    task automatic restart();
        enable = 1'b0;
        step1();
        step1();
        enable = 1'b1;
        step1();
        t = 0;
    endtask

    task automatic check_vec(input logic [36:0] v);
        chk("R2", "hsync", int'(hsync), int'(v[20]));
        chk("R2", "vsync", int'(vsync), int'(v[19]));
        chk("R3", "blank", int'(blank), int'(v[18]));
        chk("R3", "de",    int'(de),    int'(v[17]));
        chk("R5", "irq",   int'(vevent_irq), int'(v[16]));
        chk("R4", "x",     int'(pix_x), int'(v[15:8]));
        chk("R4", "y",     int'(pix_y), int'(v[7:0]));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int irqs;
        @(negedge clk);
        @(negedge clk);
        // R10: reset state is stopped with all strobes inactive
        chk("R10", "hsync at reset", int'(hsync), 0);
        chk("R10", "vsync at reset", int'(vsync), 0);
        chk("R10", "blank at reset", int'(blank), 0);
        chk("R10", "de at reset",    int'(de),    0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk over one frame plus the wrap (R1..R5, R7 start at origin)
        restart();
        for (int i = 0; i < NV; i++) begin
            adv_to(int'(VEC[i][36:21]));
            check_vec(VEC[i]);
        end
        // R1: the frame origin repeats after 28*13 clocks
        chk("R1", "hsync at wrap", int'(hsync), 1);

        // R6: active-low polarities
        hs_pol = 1'b0; vs_pol = 1'b0; blank_pol = 1'b0;
        restart();
        chk("R6", "hsync low-active in sync", int'(hsync), 0);
        chk("R6", "vsync low-active in sync", int'(vsync), 0);
        chk("R6", "blank low-active blanking", int'(blank), 0);
        adv_to(119);
        chk("R6", "hsync outside sync", int'(hsync), 1);
        chk("R6", "vsync outside sync", int'(vsync), 1);
        chk("R6", "blank in window", int'(blank), 1);
        hs_pol = 1'b1; vs_pol = 1'b1; blank_pol = 1'b1;

        // R7: stop mid-window parks all outputs
        restart();
        adv_to(119);
        chk("R7", "de before stop", int'(de), 1);
        enable = 1'b0;
        step1();
        chk("R7", "hsync stopped", int'(hsync), 0);
        chk("R7", "vsync stopped", int'(vsync), 0);
        chk("R7", "blank stopped", int'(blank), 0);
        chk("R7", "de stopped",    int'(de),    0);
        chk("R7", "x stopped",     int'(pix_x), 0);
        irqs = 0;
        for (int k = 0; k < 400; k++) begin
            step1();
            if (vevent_irq) irqs++;
        end
        chk("R7", "irq pulses while stopped", irqs, 0);

        // R9: mid-frame write to H_ACT_START (addr 2) waits for the next frame
        restart();
        adv_to(5);
        wr(2, 9);
        adv_to(119);
        chk("R9", "old start still live: de", int'(de), 1);
        chk("R9", "old start still live: x", int'(pix_x), 0);
        adv_to(364 + 119);
        chk("R9", "new start: de at col 7", int'(de), 0);
        adv_to(364 + 121);
        chk("R9", "new start: de at col 9", int'(de), 1);
        chk("R9", "new start: x at col 9", int'(pix_x), 0);
        adv_to(364 + 134);
        chk("R4", "x with start 9", int'(pix_x), 13);
        enable = 1'b0;
        step1();
        wr(2, 7);

        // R5/R8: V_EVENT (addr 8) moved to line 3 while stopped
        wr(8, 3);
        restart();
        adv_to(84);
        chk("R5", "irq at line 3", int'(vevent_irq), 1);
        step1();
        chk("R5", "irq one cycle", int'(vevent_irq), 0);
        adv_to(280);
        chk("R8", "irq gone from line 10", int'(vevent_irq), 0);
        enable = 1'b0;
        step1();
        wr(8, 10);

        // R8: write to an unused address (12) changes no timing
        wr(12, 0);
        restart();
        adv_to(119);
        chk("R8", "de after bad addr", int'(de), 1);
        chk("R8", "x after bad addr", int'(pix_x), 0);
        adv_to(363);
        chk("R8", "vsync end of frame", int'(vsync), 0);
        adv_to(364);
        chk("R8", "hsync frame length kept", int'(hsync), 1);
        chk("R8", "vsync frame length kept", int'(vsync), 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule